// File: doc/BRIEF.md
# Pulse-Gap Downlink Command Transmitter

This block sends one command frame from a low-frequency reader to a transponder by switching the reader's field on and off. When a command strobe arrives, it builds the frame from the command flags, the 32-bit data word, the 32-bit password and the 3-bit block address. It then turns the field off for a start gap. After that it sends each symbol as a field-on period, whose length encodes the symbol value, followed by a fixed field-off gap. All times are counted in ticks of an external 1 µs strobe.

Four downlink encodings can be selected. Fixed-bit and long-reference use two pulse lengths. Long-reference also sends one extra-long reference pulse before the frame. Leading-zero prefixes the frame with a 0 and shortens the 1 pulse. One-of-four prefixes two 0s and sends bits in pairs, using four pulse lengths. Between commands the field stays on, so the transponder keeps its power. A one-clock done pulse marks the end of each frame.

Top module: `lf_downlink_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `field_en` is 1, `busy` is 0 and `done` is 0.
- R2: A command that is not a reset command sends its fields in this order, each most significant bit first: mode prefix, opcode `1` then the page bit, lock bit 0, 32 data bits, 3 address bits.
- R3: When `reset_cmd` is 1, the frame is the mode prefix followed by opcode `00` and nothing else. Password, test, read and page inputs have no effect.
- R4: When `test_en` is 1 and `reset_cmd` is 0, the opcode is `01` whatever the page bit is.
- R5: When `pwd_en` is 1, the 32 password bits follow the opcode. In leading-zero (`dl_mode`=2) and one-of-four (`dl_mode`=3) modes, two 0 bits come before the password.
- R6: When `reg_read` is 1, the lock bit and the address are left out. When `read_cmd` is 1, the data bits are left out.
- R7: A frame starts with `T_START` ticks of field off. Every symbol, including the reference symbol, is followed by exactly `T_GAP` ticks of field off. The field changes during a frame only on a tick.
- R8: In fixed (`dl_mode`=0) and long-reference (`dl_mode`=1) modes, a 0 is `T_ZERO` ticks on and a 1 is `T_ONE` ticks on. In leading-zero mode a 1 is `T_ONE_LZ` ticks on, and one 0 is sent before the opcode.
- R9: In one-of-four mode, two 0s are sent before the opcode. Bits are then paired with the earlier bit as the MSB, and the pairs 00, 01, 10 and 11 are sent as `T_ZERO`, `T_Q01`, `T_Q10` and `T_Q11` ticks on.
- R10: In long-reference mode, a reference pulse of `T_ZERO + T_REF_EXTRA` ticks on, plus its gap, comes after the start gap and before the first bit.
- R11: After the last gap, `done` is 1 for exactly one clock. `field_en` returns to 1 and `busy` drops in that same clock.
- R12: A `cmd_start` pulse while `busy` is 1 is ignored. The frame in progress keeps the mode and fields captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-clock strobe once per microsecond |
| cmd_start | input | 1 | Starts a frame when idle |
| cmd_data | input | 32 | Data word for a write |
| cmd_pwd | input | 32 | Password |
| cmd_addr | input | 3 | Block address |
| pwd_en | input | 1 | Include the password |
| page_sel | input | 1 | Page bit of the opcode |
| test_en | input | 1 | Test opcode |
| reset_cmd | input | 1 | Reset command (opcode 00 only) |
| reg_read | input | 1 | Leave out the lock bit and the address |
| read_cmd | input | 1 | Leave out the data |
| dl_mode | input | 2 | 0 fixed, 1 long reference, 2 leading zero, 3 one-of-four |
| field_en | output | 1 | Reader field enable |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-clock pulse at the end of a frame |

## Verification
The bench builds the block with short timing parameters: start gap 10, gap 4, zero 3, one 9, leading-zero one 7, pairs 5/8/12, reference extra 20. It drives the tick every second clock. With these values, full 74-bit frames and dozens of random commands in all four modes fit into the run. Because every symbol length is distinct, a swapped code, a wrong field order or a dropped bit changes the measured pulse train.

// File: rtl/dl_pkg.sv
// Shared types for the downlink transmitter.
// Assumes the frame buffer is wide enough for the longest frame (74 bits).
package dl_pkg;
    localparam int FRAME_W = 80;
    localparam int LEN_W   = 7;

    typedef enum logic [1:0] {
        MODE_FIXED   = 2'd0,
        MODE_LONGREF = 2'd1,
        MODE_LEAD0   = 2'd2,
        MODE_QUAD    = 2'd3
    } dl_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SGAP,
        ST_REF,
        ST_SYM,
        ST_GAP
    } dl_state_e;

    typedef struct packed {
        logic pwd_en;
        logic page;
        logic test_en;
        logic reset_cmd;
        logic reg_read;
        logic read_cmd;
    } dl_flags_t;
endpackage

// File: rtl/dl_frame_pack.sv
// Builds the downlink bit frame from the command fields.
// The output is left-aligned: the first bit to send sits at the MSB.
// Assumes the inputs are stable in the cycle in which the frame is captured.
module dl_frame_pack
    import dl_pkg::*;
#(
    parameter int FW = FRAME_W,
    parameter int LW = LEN_W
) (
    input  logic [31:0]   data_i,
    input  logic [31:0]   pwd_i,
    input  logic [2:0]    addr_i,
    input  dl_flags_t     flags_i,
    input  dl_mode_e      mode_i,
    output logic [FW-1:0] frame_o,
    output logic [LW-1:0] nbits_o
);
    logic [FW-1:0] f_acc;
    logic [LW-1:0] n_acc;
    logic          lead;

    // Append the fields in send order into a right-growing accumulator.
    always_comb begin
        lead  = (mode_i == MODE_LEAD0) || (mode_i == MODE_QUAD);
        f_acc = '0;
        n_acc = '0;
        if (lead) begin
            f_acc = {f_acc[FW-2:0], 1'b0};
            n_acc = n_acc + LW'(1);
        end
        if (mode_i == MODE_QUAD) begin
            f_acc = {f_acc[FW-2:0], 1'b0};
            n_acc = n_acc + LW'(1);
        end
        if (flags_i.reset_cmd) begin
            f_acc = {f_acc[FW-3:0], 2'b00};
            n_acc = n_acc + LW'(2);
        end else begin
            f_acc = {f_acc[FW-3:0], (flags_i.test_en ? 2'b01 : {1'b1, flags_i.page})};
            n_acc = n_acc + LW'(2);
            if (flags_i.pwd_en) begin
                if (lead) begin
                    f_acc = {f_acc[FW-3:0], 2'b00};
                    n_acc = n_acc + LW'(2);
                end
                f_acc = {f_acc[FW-33:0], pwd_i};
                n_acc = n_acc + LW'(32);
            end
            if (!flags_i.reg_read) begin
                f_acc = {f_acc[FW-2:0], 1'b0};
                n_acc = n_acc + LW'(1);
            end
            if (!flags_i.read_cmd) begin
                f_acc = {f_acc[FW-33:0], data_i};
                n_acc = n_acc + LW'(32);
            end
            if (!flags_i.reg_read) begin
                f_acc = {f_acc[FW-4:0], addr_i};
                n_acc = n_acc + LW'(3);
            end
        end
    end

    // Move the first bit to the MSB.
    always_comb begin
        frame_o = f_acc << (LW'(FW) - n_acc);
        nbits_o = n_acc;
    end
endmodule

// File: rtl/dl_sym_len.sv
// Maps a symbol code to its field-on length in ticks for the selected mode.
// Assumes the code is {0, bit} outside one-of-four mode.
module dl_sym_len
    import dl_pkg::*;
#(
    parameter int T_ZERO      = 144,
    parameter int T_ONE       = 400,
    parameter int T_ONE_LZ    = 320,
    parameter int T_Q01       = 272,
    parameter int T_Q10       = 400,
    parameter int T_Q11       = 528,
    parameter int T_REF_EXTRA = 1088,
    parameter int CW          = 12
) (
    input  dl_mode_e      mode_i,
    input  logic [1:0]    code_i,
    input  logic          ref_i,
    output logic [CW-1:0] len_o
);
    // Choose the on-time from the reference flag, the mode and the code.
    always_comb begin
        if (ref_i) begin
            len_o = CW'(T_ZERO + T_REF_EXTRA);
        end else if (mode_i == MODE_QUAD) begin
            case (code_i)
                2'b00:   len_o = CW'(T_ZERO);
                2'b01:   len_o = CW'(T_Q01);
                2'b10:   len_o = CW'(T_Q10);
                default: len_o = CW'(T_Q11);
            endcase
        end else if (code_i[0]) begin
            len_o = (mode_i == MODE_LEAD0) ? CW'(T_ONE_LZ) : CW'(T_ONE);
        end else begin
            len_o = CW'(T_ZERO);
        end
    end
endmodule

// File: rtl/dl_seq.sv
// Segment sequencer: start gap, optional reference, then symbol and gap pairs.
// It captures the frame and the mode on a start while idle, and counts ticks per segment.
// Assumes every segment length is at least one tick.
module dl_seq
    import dl_pkg::*;
#(
    parameter int FW      = FRAME_W,
    parameter int LW      = LEN_W,
    parameter int CW      = 12,
    parameter int T_START = 248,
    parameter int T_GAP   = 160
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          start_i,
    input  logic [FW-1:0] frame_i,
    input  logic [LW-1:0] nbits_i,
    input  dl_mode_e      mode_i,
    input  logic [CW-1:0] sym_len_i,
    output dl_mode_e      mode_o,
    output logic [1:0]    code_o,
    output logic          ref_o,
    output logic          field_o,
    output logic          busy_o,
    output logic          done_o
);
    dl_state_e     state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] seg_len;
    logic [FW-1:0] frm;
    logic [LW-1:0] rem;
    dl_mode_e      mode_q;
    logic          field_q;
    logic          done_q;
    logic          seg_end;
    logic          quad;

    // Segment length and end-of-segment detection.
    always_comb begin
        quad = (mode_q == MODE_QUAD);
        case (state)
            ST_SGAP: seg_len = CW'(T_START);
            ST_GAP:  seg_len = CW'(T_GAP);
            default: seg_len = sym_len_i;
        endcase
        seg_end = tick_i && (cnt == seg_len - CW'(1));
        code_o  = quad ? frm[FW-1:FW-2] : {1'b0, frm[FW-1]};
        ref_o   = (state == ST_REF);
    end

    // State, tick counter, frame shifter and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            frm     <= '0;
            rem     <= '0;
            mode_q  <= MODE_FIXED;
            field_q <= 1'b1;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state == ST_IDLE) begin
                if (start_i) begin
                    frm     <= frame_i;
                    mode_q  <= mode_i;
                    rem     <= (mode_i == MODE_QUAD) ? (nbits_i >> 1) : nbits_i;
                    cnt     <= '0;
                    field_q <= 1'b0;
                    state   <= ST_SGAP;
                end
            end else if (tick_i) begin
                if (!seg_end) begin
                    cnt <= cnt + CW'(1);
                end else begin
                    cnt <= '0;
                    case (state)
                        ST_SGAP: begin
                            field_q <= 1'b1;
                            state   <= (mode_q == MODE_LONGREF) ? ST_REF : ST_SYM;
                        end
                        ST_REF: begin
                            field_q <= 1'b0;
                            state   <= ST_GAP;
                        end
                        ST_SYM: begin
                            field_q <= 1'b0;
                            frm     <= quad ? (frm << 2) : (frm << 1);
                            rem     <= rem - LW'(1);
                            state   <= ST_GAP;
                        end
                        default: begin
                            field_q <= 1'b1;
                            if (rem == '0) begin
                                done_q <= 1'b1;
                                state  <= ST_IDLE;
                            end else begin
                                state  <= ST_SYM;
                            end
                        end
                    endcase
                end
            end
        end
    end

    assign mode_o  = mode_q;
    assign field_o = field_q;
    assign done_o  = done_q;
    assign busy_o  = (state != ST_IDLE);
endmodule

// File: rtl/lf_downlink_tx.sv
// Top of the pulse-gap downlink transmitter: frame packer, symbol length table
// and segment sequencer. All timing parameters are in ticks of tick_us.
// Assumes tick_us is a single-clock strobe.
module lf_downlink_tx
    import dl_pkg::*;
#(
    parameter int T_START     = 248,
    parameter int T_GAP       = 160,
    parameter int T_ZERO      = 144,
    parameter int T_ONE       = 400,
    parameter int T_ONE_LZ    = 320,
    parameter int T_Q01       = 272,
    parameter int T_Q10       = 400,
    parameter int T_Q11       = 528,
    parameter int T_REF_EXTRA = 1088
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_us,
    input  logic        cmd_start,
    input  logic [31:0] cmd_data,
    input  logic [31:0] cmd_pwd,
    input  logic [2:0]  cmd_addr,
    input  logic        pwd_en,
    input  logic        page_sel,
    input  logic        test_en,
    input  logic        reset_cmd,
    input  logic        reg_read,
    input  logic        read_cmd,
    input  logic [1:0]  dl_mode,
    output logic        field_en,
    output logic        busy,
    output logic        done
);
    localparam int CNT_W = $clog2(T_START + T_GAP + T_ZERO + T_ONE + T_ONE_LZ
                                  + T_Q01 + T_Q10 + T_Q11 + T_REF_EXTRA + 1);

    dl_flags_t          flags;
    dl_mode_e           mode_in;
    dl_mode_e           mode_q;
    logic [FRAME_W-1:0] frame;
    logic [LEN_W-1:0]   nbits;
    logic [1:0]         code;
    logic               ref_now;
    logic [CNT_W-1:0]   sym_len;

    assign flags   = '{pwd_en: pwd_en, page: page_sel, test_en: test_en,
                       reset_cmd: reset_cmd, reg_read: reg_read, read_cmd: read_cmd};
    assign mode_in = dl_mode_e'(dl_mode);

    dl_frame_pack #(.FW(FRAME_W), .LW(LEN_W)) u_pack (
        .data_i  (cmd_data),
        .pwd_i   (cmd_pwd),
        .addr_i  (cmd_addr),
        .flags_i (flags),
        .mode_i  (mode_in),
        .frame_o (frame),
        .nbits_o (nbits)
    );

    dl_sym_len #(
        .T_ZERO(T_ZERO), .T_ONE(T_ONE), .T_ONE_LZ(T_ONE_LZ), .T_Q01(T_Q01),
        .T_Q10(T_Q10), .T_Q11(T_Q11), .T_REF_EXTRA(T_REF_EXTRA), .CW(CNT_W)
    ) u_len (
        .mode_i (mode_q),
        .code_i (code),
        .ref_i  (ref_now),
        .len_o  (sym_len)
    );

    dl_seq #(
        .FW(FRAME_W), .LW(LEN_W), .CW(CNT_W), .T_START(T_START), .T_GAP(T_GAP)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_us),
        .start_i   (cmd_start),
        .frame_i   (frame),
        .nbits_i   (nbits),
        .mode_i    (mode_in),
        .sym_len_i (sym_len),
        .mode_o    (mode_q),
        .code_o    (code),
        .ref_o     (ref_now),
        .field_o   (field_en),
        .busy_o    (busy),
        .done_o    (done)
    );
endmodule

// File: rtl/lf_downlink_tx_check.sv
// Protocol checks for lf_downlink_tx, attached by bind.
module lf_downlink_tx_check (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_us,
    input logic       cmd_start,
    input logic       field_en,
    input logic       busy,
    input logic       done,
    input logic [1:0] mode_q
);
    p_idle_field_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> field_en);

    p_done_one_clock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ends_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && field_en && $past(busy)));

    p_start_gap_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !busy) |=> (busy && !field_en));

    p_field_moves_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && (field_en != $past(field_en))) |-> $past(tick_us));

    p_mode_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mode_q));
endmodule

bind lf_downlink_tx lf_downlink_tx_check u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_us   (tick_us),
    .cmd_start (cmd_start),
    .field_en  (field_en),
    .busy      (busy),
    .done      (done),
    .mode_q    (mode_q)
);

// File: tb/lf_downlink_tx_bench.sv
module lf_downlink_tx_bench;
    localparam int TS = 10, TG = 4, TZ = 3, T1 = 9, T1L = 7;
    localparam int Q1 = 5, Q2 = 8, Q3 = 12, TR = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_us = 1'b0;
    logic        cmd_start = 1'b0;
    logic [31:0] cmd_data = '0;
    logic [31:0] cmd_pwd = '0;
    logic [2:0]  cmd_addr = '0;
    logic        pwd_en = 1'b0, page_sel = 1'b0, test_en = 1'b0;
    logic        reset_cmd = 1'b0, reg_read = 1'b0, read_cmd = 1'b0;
    logic [1:0]  dl_mode = '0;
    logic        field_en, busy, done;

    int total = 0;
    int bad = 0;
    int eb [0:127];
    int nb;
    int ed [0:127];
    int ne;
    int rl [0:255];
    int nr;

    lf_downlink_tx #(
        .T_START(TS), .T_GAP(TG), .T_ZERO(TZ), .T_ONE(T1), .T_ONE_LZ(T1L),
        .T_Q01(Q1), .T_Q10(Q2), .T_Q11(Q3), .T_REF_EXTRA(TR)
    ) u_lf_downlink_tx (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .cmd_start(cmd_start),
        .cmd_data(cmd_data), .cmd_pwd(cmd_pwd), .cmd_addr(cmd_addr),
        .pwd_en(pwd_en), .page_sel(page_sel), .test_en(test_en),
        .reset_cmd(reset_cmd), .reg_read(reg_read), .read_cmd(read_cmd),
        .dl_mode(dl_mode), .field_en(field_en), .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            #2 tick_us = ~tick_us;
        end
    end

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic put(input logic [31:0] v, input int w);
        for (int i = w - 1; i >= 0; i--) begin
            eb[nb] = int'(v[i]);
            nb++;
        end
    endtask

    function automatic int on_len(input int m, input int code);
        if (m == 3) return (code == 0) ? TZ : (code == 1) ? Q1 : (code == 2) ? Q2 : Q3;
        if (code == 0) return TZ;
        return (m == 2) ? T1L : T1;
    endfunction

    // Expected list of field-on lengths, from the requirements.
    task automatic build_exp(input int m);
        bit lead;
        lead = (m == 2) || (m == 3);
        nb = 0;
        ne = 0;
        if (lead) put(32'd0, 1);
        if (m == 3) put(32'd0, 1);
        if (reset_cmd) put(32'd0, 2);
        else begin
            if (test_en) put(32'd1, 2);
            else put({31'd1, page_sel}, 2);
            if (pwd_en) begin
                if (lead) put(32'd0, 2);
                put(cmd_pwd, 32);
            end
            if (!reg_read) put(32'd0, 1);
            if (!read_cmd) put(cmd_data, 32);
            if (!reg_read) put({29'd0, cmd_addr}, 3);
        end
        if (m == 1) begin
            ed[ne] = TZ + TR;
            ne++;
        end
        if (m == 3) begin
            for (int i = 0; i + 1 < nb; i += 2) begin
                ed[ne] = on_len(m, eb[i] * 2 + eb[i + 1]);
                ne++;
            end
        end else begin
            for (int i = 0; i < nb; i++) begin
                ed[ne] = on_len(m, eb[i]);
                ne++;
            end
        end
    endtask

    task automatic run_frame(input string tag, input bit intrude);
        int cyc;
        int cnt;
        bit prev;
        bit got_done;
        int bad_on;
        int bad_gap;
        int first_bad;
        build_exp(int'(dl_mode));
        @(negedge clk);
        cmd_start = 1'b1;
        prev = field_en;
        cnt = 0;
        nr = 0;
        cyc = 0;
        got_done = 1'b0;
        while (!got_done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) cmd_start = 1'b0;
            if (intrude && cyc == 40) begin
                cmd_start = 1'b1;
                dl_mode = ~dl_mode;
                cmd_data = ~cmd_data;
                reset_cmd = ~reset_cmd;
            end
            if (intrude && cyc == 41) cmd_start = 1'b0;
            if (field_en != prev) begin
                if (nr < 256) rl[nr] = cnt;
                nr++;
                prev = field_en;
                cnt = 0;
            end
            if (tick_us) cnt++;
            if (done) got_done = 1'b1;
        end
        chk(got_done, "R11 frame ended with done", int'(got_done), 1);
        chk(nr > 1 && rl[1] == TS, "R7 start gap ticks", (nr > 1) ? rl[1] : -1, TS);
        chk((nr - 2) / 2 == ne, {tag, " symbol count"}, (nr - 2) / 2, ne);
        bad_on = 0;
        bad_gap = 0;
        first_bad = -1;
        for (int k = 0; k < ne && 2 + 2 * k + 1 < nr; k++) begin
            if (rl[2 + 2 * k] != ed[k]) begin
                bad_on++;
                if (first_bad < 0) first_bad = k;
            end
            if (rl[3 + 2 * k] != TG) bad_gap++;
        end
        chk(bad_on == 0, {tag, " on-time of symbol"},
            (first_bad >= 0) ? rl[2 + 2 * first_bad] : 0,
            (first_bad >= 0) ? ed[first_bad] : 0);
        chk(bad_gap == 0, "R7 write gap mismatches", bad_gap, 0);
        @(negedge clk);
        chk(!done && field_en && !busy, "R11 done single clock, field on, idle",
            {29'd0, done, field_en, busy}, 2);
    endtask

    task automatic set_cmd(input int m, input bit pw, input bit pg, input bit ts,
                           input bit rs, input bit rr, input bit rd,
                           input logic [31:0] d, input logic [31:0] p, input logic [2:0] a);
        dl_mode = 2'(m);
        pwd_en = pw;
        page_sel = pg;
        test_en = ts;
        reset_cmd = rs;
        reg_read = rr;
        read_cmd = rd;
        cmd_data = d;
        cmd_pwd = p;
        cmd_addr = a;
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(field_en == 1'b1, "R1 field on in reset", int'(field_en), 1);
        chk(busy == 1'b0, "R1 busy low in reset", int'(busy), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && field_en && !done, "R1 idle after reset",
            {29'd0, busy, field_en, done}, 2);

        set_cmd(0, 0, 0, 0, 0, 0, 0, 32'h8000_0001, 32'h0, 3'd5);
        run_frame("R2 R8 fixed write", 1'b0);
        set_cmd(0, 0, 1, 0, 0, 0, 0, 32'hA5C3_0F96, 32'h0, 3'd2);
        run_frame("R2 fixed write page1", 1'b0);
        set_cmd(0, 1, 1, 1, 1, 0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd7);
        run_frame("R3 reset command", 1'b0);
        set_cmd(3, 1, 0, 0, 1, 1, 1, 32'h1234_5678, 32'hFFFF_0000, 3'd1);
        run_frame("R3 R9 reset in one-of-four", 1'b0);
        set_cmd(0, 0, 1, 1, 0, 0, 0, 32'h0F0F_0F0F, 32'h0, 3'd3);
        run_frame("R4 test opcode", 1'b0);
        set_cmd(2, 1, 0, 0, 0, 0, 0, 32'hDEAD_BEEF, 32'h5555_AAAA, 3'd6);
        run_frame("R5 R8 leading-zero password write", 1'b0);
        set_cmd(0, 1, 0, 0, 0, 1, 1, 32'hFFFF_FFFF, 32'h8001_7FFE, 3'd7);
        run_frame("R5 R6 fixed password reg-read", 1'b0);
        set_cmd(1, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF, 32'h0, 3'd4);
        run_frame("R6 R10 long-reference read", 1'b0);
        set_cmd(1, 1, 1, 0, 0, 0, 0, 32'h0000_FFFF, 32'h1357_9BDF, 3'd0);
        run_frame("R10 R8 long-reference write", 1'b0);
        set_cmd(3, 1, 1, 0, 0, 0, 0, 32'hE4E4_1B1B, 32'h3C3C_C3C3, 3'd5);
        run_frame("R9 R5 one-of-four longest frame", 1'b0);
        set_cmd(3, 0, 0, 0, 0, 1, 1, 32'h0, 32'h0, 3'd6);
        run_frame("R9 R6 one-of-four short read", 1'b0);
        set_cmd(0, 0, 0, 0, 0, 0, 0, 32'hC0FF_EE00, 32'h0, 3'd1);
        run_frame("R12 restart ignored while busy", 1'b1);

        for (int n = 0; n < 28; n++) begin
            set_cmd(int'($urandom % 4), $urandom % 2 == 0, $urandom % 2 == 0,
                    $urandom % 5 == 0, $urandom % 8 == 0, $urandom % 3 == 0,
                    $urandom % 3 == 0, $urandom, $urandom, 3'($urandom));
            run_frame("R2 random command", n % 7 == 3);
        end

        summary();
        $finish;
    end
endmodule